// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache Controller

This block places a 4 KB direct-mapped cache between one processor port and a slower memory port. Each of its 1024 lines holds a single 32-bit word, together with a 20-bit tag and a valid bit. A processor access is looked up in the line picked by the middle address bits. A read hit answers in the same cycle it is presented. A read miss holds the processor while the word is fetched over a request/acknowledge memory handshake. The fetched word is then installed.

Every write is sent through to memory, and the processor waits for the memory acknowledge. A write hit also refreshes the cached word. A run-time input chooses what a write miss does: it either installs the written word as a new line or leaves the cache untouched. Two counters report how many lookups hit and how many missed.

Top module: `dm_cache`

## Requirements
- R1: While `rst_n` is low at a clock edge, every line becomes invalid in that single cycle and both counters clear. After reset, `cpu_ready` and `mem_req` are low.
- R2: The byte address is split into fields. Bits [1:0] select a byte and take no part in lookup. Bits [11:2] pick one of 1024 lines. Bits [31:12] form the 20-bit tag. Memory addresses are always issued word-aligned, with bits [1:0] = 0.
- R3: A lookup hits only when the indexed line is valid and its stored tag equals address bits [31:12]. A read hit raises `cpu_ready` in the same cycle as the request, returns the cached word and makes no memory access.
- R4: A read miss issues a memory read (`mem_we` = 0) in the following cycle. `cpu_ready` rises in the cycle of `mem_ack`, with `cpu_rdata` equal to `mem_rdata`. The line is then valid with the new tag and word.
- R5: Once raised, `mem_req` stays high with a stable address and direction until `mem_ack`. `cpu_ready` stays low for a missed or written access until that acknowledge.
- R6: Every write issues a memory write (`mem_we` = 1) of `cpu_wdata` and completes in the `mem_ack` cycle. A write hit also updates the cached word. No write ever fetches from memory.
- R7: With `write_around` = 1, a write miss leaves the line it indexes unchanged. That line keeps its previous contents and validity.
- R8: With `write_around` = 0, a write miss installs the written word and its tag. A later read of that address hits.
- R9: Each accepted access adds exactly one to `hit_count` (on a hit) or to `miss_count` (on a miss), at the end of its lookup cycle.
- R10: From reset, byte reads of 0, 4, 8188, 0, 16384, 0 give exactly 1 hit and 5 misses. Address 8188 uses line 1023, and address 16384 evicts line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| write_around | input | 1 | Write-miss policy: 1 = do not install, 0 = install |
| cpu_req | input | 1 | Processor access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Processor byte address |
| cpu_wdata | input | 32 | Processor write data |
| cpu_rdata | output | 32 | Read data, valid while `cpu_ready` is high on a read |
| cpu_ready | output | 1 | One-cycle completion of the current access |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | Memory direction: 1 = write |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory completion, one cycle |
| hit_count | output | 32 | Number of lookups that hit |
| miss_count | output | 32 | Number of lookups that missed |

## Verification
A read hit must show `cpu_ready` in the very cycle the request is driven, so the bench counts zero wait cycles for it. Read misses and all writes must complete in the cycle the memory model raises its acknowledge. The model acknowledges a set number of cycles after it first sees `mem_req`, so the bench expects exactly that many waits. Each lookup result shows in the counters one edge after the request cycle, and the bench compares the counters only after the access completes. All values are sampled two nanoseconds after a falling edge, well away from the rising edge where state changes.

// File: rtl/dmc_pkg.sv
// Shared types for the direct-mapped cache.
// Assumes: nothing beyond IEEE 1800-2017.
package dmc_pkg;
    // Controller phases: idle lookup, line fetch, write-through.
    typedef enum logic [1:0] {
        ST_LOOKUP = 2'd0,
        ST_FILL   = 2'd1,
        ST_WRITE  = 2'd2
    } dmc_state_e;
endpackage

// File: rtl/dmc_line_store.sv
// Line storage: a valid-bit register vector plus tag and data arrays.
// Valid bits clear together in one reset cycle; tag and data arrays
// have no reset and are only trusted where the valid bit is set.
// Assumes: one asynchronous read port and one write port on the same clock.
module dmc_line_store #(
    parameter int LINES  = 1024,
    parameter int TAG_W  = 20,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data
);
    logic [LINES-1:0]  vld_q;
    logic [TAG_W-1:0]  tag_mem [LINES];
    logic [DATA_W-1:0] dat_mem [LINES];

    // Valid bits: all cleared at once in reset, set on any line write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            vld_q <= '0;
        else if (wr_en)
            vld_q[wr_idx] <= 1'b1;
    end

    // Tag and data arrays: plain write port, no reset.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx] <= wr_tag;
            dat_mem[wr_idx] <= wr_data;
        end
    end

    // Read port: combinational view of the indexed line.
    always_comb begin
        rd_valid = vld_q[rd_idx];
        rd_tag   = tag_mem[rd_idx];
        rd_data  = dat_mem[rd_idx];
    end

    // R1: one reset cycle leaves every line invalid.
    a_r1_all_invalid: assert property (@(posedge clk)
        !rst_n |=> (vld_q == '0));

    // R4: a written line is valid on the next cycle.
    a_r4_line_valid: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> vld_q[$past(wr_idx)]);
endmodule

// File: rtl/dmc_ctrl.sv
// Cache controller: splits the address, decides hit or miss, runs the
// fetch and write-through handshakes, and drives the line store.
// Assumes: the processor holds cpu_req and its fields stable until
// cpu_ready, then drops cpu_req for at least one cycle; memory answers
// each request with a one-cycle mem_ack.
module dmc_ctrl
    import dmc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 10,
    parameter int OFFS_W = 2,
    localparam int TAG_W = ADDR_W - IDX_W - OFFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              write_around,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic [IDX_W-1:0]  ls_idx,
    input  logic              ls_valid,
    input  logic [TAG_W-1:0]  ls_tag,
    input  logic [DATA_W-1:0] ls_data,
    output logic              ls_wr_en,
    output logic [TAG_W-1:0]  ls_wr_tag,
    output logic [DATA_W-1:0] ls_wr_data,
    output logic              hit_inc,
    output logic              miss_inc
);
    dmc_state_e state_q, state_d;
    logic       around_q;
    logic       wr_hit_q;
    logic       lookup_hit;
    logic [TAG_W-1:0] addr_tag;

    // Address fields: index selects the line, tag is compared.
    always_comb begin
        ls_idx     = cpu_addr[OFFS_W +: IDX_W];
        addr_tag   = cpu_addr[ADDR_W-1 -: TAG_W];
        lookup_hit = ls_valid && (ls_tag == addr_tag);
        mem_addr   = {cpu_addr[ADDR_W-1:OFFS_W], {OFFS_W{1'b0}}};
        mem_wdata  = cpu_wdata;
        ls_wr_tag  = addr_tag;
    end

    // Next state, processor/memory strobes and line-store writes.
    always_comb begin
        state_d    = state_q;
        cpu_ready  = 1'b0;
        cpu_rdata  = '0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        ls_wr_en   = 1'b0;
        ls_wr_data = cpu_wdata;
        hit_inc    = 1'b0;
        miss_inc   = 1'b0;
        case (state_q)
            ST_LOOKUP: begin
                if (cpu_req) begin
                    hit_inc  = lookup_hit;
                    miss_inc = !lookup_hit;
                    if (cpu_we) begin
                        state_d = ST_WRITE;
                    end else if (lookup_hit) begin
                        cpu_ready = 1'b1;
                        cpu_rdata = ls_data;
                    end else begin
                        state_d = ST_FILL;
                    end
                end
            end
            ST_FILL: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    ls_wr_en   = 1'b1;
                    ls_wr_data = mem_rdata;
                    cpu_ready  = 1'b1;
                    cpu_rdata  = mem_rdata;
                    state_d    = ST_LOOKUP;
                end
            end
            ST_WRITE: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_ack) begin
                    ls_wr_en  = wr_hit_q || !around_q;
                    cpu_ready = 1'b1;
                    state_d   = ST_LOOKUP;
                end
            end
            default: state_d = ST_LOOKUP;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_LOOKUP;
        else
            state_q <= state_d;
    end

    // Capture hit result and write policy when a write is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            around_q <= 1'b0;
            wr_hit_q <= 1'b0;
        end else if (state_q == ST_LOOKUP && cpu_req && cpu_we) begin
            around_q <= write_around;
            wr_hit_q <= lookup_hit;
        end
    end

    // R5: an open memory request keeps its address and direction until acknowledged.
    a_r5_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R5: while memory is busy, the processor completes only with the acknowledge.
    a_r5_ready_waits_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && mem_req) |-> mem_ack);

    // R4: a read miss opens a memory read on the next cycle.
    a_r4_miss_fetches: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOKUP && cpu_req && !cpu_we && !lookup_hit)
        |=> (mem_req && !mem_we));

    // R6: a write completes only together with a memory write acknowledge.
    a_r6_write_through: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && cpu_we) |-> (mem_req && mem_we && mem_ack));
endmodule

// File: rtl/dmc_stat_ctr.sv
// Event counter: adds one for every cycle its strobe is high.
// Assumes: wrap-around at the width limit is acceptable.
module dmc_stat_ctr #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    // Count strobes; clear in reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (inc)
            count <= count + W'(1);
    end
endmodule

// File: rtl/dm_cache.sv
// Direct-mapped, one-word-per-line, write-through cache with a
// selectable write-miss policy and hit/miss counters.
// Assumes: processor and memory follow the handshakes described in
// dmc_ctrl; DATA_W is a power-of-two number of bytes.
module dm_cache #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int LINES  = 1024,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              write_around,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count
);
    localparam int OFFS_W = $clog2(DATA_W / 8);
    localparam int IDX_W  = $clog2(LINES);
    localparam int TAG_W  = ADDR_W - IDX_W - OFFS_W;

    logic [IDX_W-1:0]  ls_idx;
    logic              ls_valid;
    logic [TAG_W-1:0]  ls_tag;
    logic [DATA_W-1:0] ls_data;
    logic              ls_wr_en;
    logic [TAG_W-1:0]  ls_wr_tag;
    logic [DATA_W-1:0] ls_wr_data;
    logic              hit_inc;
    logic              miss_inc;
    logic [1:0]        ev;
    logic [CNT_W-1:0]  cnt [2];

    dmc_line_store #(
        .LINES  (LINES),
        .TAG_W  (TAG_W),
        .DATA_W (DATA_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (ls_idx),
        .rd_valid (ls_valid),
        .rd_tag   (ls_tag),
        .rd_data  (ls_data),
        .wr_en    (ls_wr_en),
        .wr_idx   (ls_idx),
        .wr_tag   (ls_wr_tag),
        .wr_data  (ls_wr_data)
    );

    dmc_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W),
        .OFFS_W (OFFS_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .write_around (write_around),
        .cpu_req      (cpu_req),
        .cpu_we       (cpu_we),
        .cpu_addr     (cpu_addr),
        .cpu_wdata    (cpu_wdata),
        .cpu_rdata    (cpu_rdata),
        .cpu_ready    (cpu_ready),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_rdata    (mem_rdata),
        .mem_ack      (mem_ack),
        .ls_idx       (ls_idx),
        .ls_valid     (ls_valid),
        .ls_tag       (ls_tag),
        .ls_data      (ls_data),
        .ls_wr_en     (ls_wr_en),
        .ls_wr_tag    (ls_wr_tag),
        .ls_wr_data   (ls_wr_data),
        .hit_inc      (hit_inc),
        .miss_inc     (miss_inc)
    );

    assign ev = {miss_inc, hit_inc};

    // One counter per lookup outcome: slot 0 hits, slot 1 misses.
    for (genvar g = 0; g < 2; g++) begin : g_ctr
        dmc_stat_ctr #(.W(CNT_W)) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (ev[g]),
            .count (cnt[g])
        );
    end

    assign hit_count  = cnt[0];
    assign miss_count = cnt[1];

    // R9: the two counters together advance by at most one per cycle.
    a_r9_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((hit_count - $past(hit_count)) + (miss_count - $past(miss_count))) <= CNT_W'(1)));
endmodule

// File: tb/dm_cache_bench.sv
`timescale 1ns/1ps
module dm_cache_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        write_around = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_ready;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic [31:0] hit_count;
    logic [31:0] miss_count;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    dm_cache u_dm_cache (
        .clk(clk), .rst_n(rst_n), .write_around(write_around),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .hit_count(hit_count), .miss_count(miss_count)
    );

    // Memory model: default contents computed from the address, writes stored.
    logic [31:0] wmem [logic [31:0]];
    int          mem_lat = 2;
    int          wait_n = 0;
    int          rd_cnt = 0;
    int          wr_cnt = 0;
    logic [31:0] last_addr = '0;

    function automatic logic [31:0] model_word(input logic [31:0] a);
        logic [31:0] w;
        w = {a[31:2], 2'b00};
        if (wmem.exists(w)) return wmem[w];
        return (w ^ 32'h1357_9BDF) + 32'h0101_0000;
    endfunction

    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            wait_n++;
            if (wait_n >= mem_lat) begin
                wait_n    = 0;
                last_addr = mem_addr;
                if (mem_we) begin
                    wmem[mem_addr] = mem_wdata;
                    wr_cnt++;
                end else begin
                    mem_rdata = model_word(mem_addr);
                    rd_cnt++;
                end
                mem_ack = 1'b1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One processor access; returns read data and wait cycles before ready.
    task automatic access(input logic we, input logic [31:0] addr, input logic [31:0] wd,
                          output logic [31:0] rd, output int cyc);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
        cyc = 0;
        forever begin
            #2;
            if (cpu_ready) break;
            @(negedge clk);
            cyc++;
            if (cyc > 200) break;
        end
        rd = cpu_rdata;
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    // Access plus the checks common to every access.
    task automatic step(input string req, input logic we, input logic [31:0] addr,
                        input logic [31:0] wd, input bit exp_hit);
        logic [31:0] rd, exp_d, h0, m0;
        int cyc, r0, w0;
        h0 = hit_count; m0 = miss_count; r0 = rd_cnt; w0 = wr_cnt;
        exp_d = model_word(addr);
        access(we, addr, wd, rd, cyc);
        check(hit_count == h0 + (exp_hit ? 1 : 0), req, "R9 hit_count", hit_count, h0 + (exp_hit ? 1 : 0));
        check(miss_count == m0 + (exp_hit ? 0 : 1), req, "R9 miss_count", miss_count, m0 + (exp_hit ? 0 : 1));
        if (we) begin
            check(cyc == mem_lat, req, "R6 write waits for ack", cyc, mem_lat);
            check(wr_cnt == w0 + 1, req, "R6 memory write issued", wr_cnt, w0 + 1);
            check(rd_cnt == r0, req, "R6 no fetch on write", rd_cnt, r0);
            check(last_addr == {addr[31:2], 2'b00}, req, "R2 aligned mem address", last_addr, {addr[31:2], 2'b00});
        end else if (exp_hit) begin
            check(cyc == 0, req, "R3 hit ready same cycle", cyc, 0);
            check(rd_cnt == r0, req, "R3 hit no memory read", rd_cnt, r0);
            check(rd == exp_d, req, "R3 hit data", rd, exp_d);
        end else begin
            check(cyc == mem_lat, req, "R4/R5 miss waits for ack", cyc, mem_lat);
            check(rd_cnt == r0 + 1, req, "R4 one memory read", rd_cnt, r0 + 1);
            check(rd == exp_d, req, "R4 miss data", rd, exp_d);
            check(last_addr == {addr[31:2], 2'b00}, req, "R2 aligned mem address", last_addr, {addr[31:2], 2'b00});
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #2;
    endtask

    localparam int NSEQ = 6;
    localparam logic [31:0] SEQ_ADDR [NSEQ] = '{32'd0, 32'd4, 32'd8188, 32'd0, 32'd16384, 32'd0};
    localparam bit          SEQ_HIT  [NSEQ] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};

    initial begin
        do_reset();
        // R1: reset state at the ports.
        check(hit_count == 0, "R1", "hit_count after reset", hit_count, 0);
        check(miss_count == 0, "R1", "miss_count after reset", miss_count, 0);
        check(cpu_ready == 0, "R1", "cpu_ready after reset", {31'd0, cpu_ready}, 0);
        check(mem_req == 0, "R1", "mem_req after reset", {31'd0, mem_req}, 0);

        // R10: reference read sequence from the table.
        for (int i = 0; i < NSEQ; i++)
            step("R10", 1'b0, SEQ_ADDR[i], '0, SEQ_HIT[i]);
        check(hit_count == 1, "R10", "total hits", hit_count, 1);
        check(miss_count == 5, "R10", "total misses", miss_count, 5);

        // R2: byte offset ignored by lookup.
        step("R2", 1'b0, 32'h0000_0003, '0, 1'b1);
        step("R2", 1'b0, 32'h0000_0006, '0, 1'b1);

        // R6: write hit goes to memory and refreshes the cached word.
        step("R6", 1'b1, 32'h0000_0004, 32'hCAFE_0004, 1'b1);
        step("R6", 1'b0, 32'h0000_0004, '0, 1'b1);

        // R7: write-around miss leaves line 1 as it was.
        write_around = 1'b1;
        step("R7", 1'b1, 32'h0010_0004, 32'hBEEF_0104, 1'b0);
        step("R7", 1'b0, 32'h0000_0004, '0, 1'b1);
        step("R7", 1'b0, 32'h0010_0004, '0, 1'b0);

        // R8: allocate-on-miss installs the written word.
        write_around = 1'b0;
        step("R8", 1'b1, 32'h0020_0008, 32'h1234_5678, 1'b0);
        step("R8", 1'b0, 32'h0020_0008, '0, 1'b1);
        step("R8", 1'b1, 32'h0030_0004, 32'h0BAD_F00D, 1'b0);
        step("R8", 1'b0, 32'h0030_0004, '0, 1'b1);
        step("R8", 1'b0, 32'h0010_0004, '0, 1'b0);

        // R5: longer memory latency stretches the stall to match.
        mem_lat = 5;
        step("R5", 1'b0, 32'h0000_0100, '0, 1'b0);
        step("R5", 1'b1, 32'h0000_0100, 32'h5555_AAAA, 1'b1);
        mem_lat = 2;

        // R1: reset mid-run invalidates every line and clears counters.
        do_reset();
        check(hit_count == 0, "R1", "hit_count after second reset", hit_count, 0);
        check(miss_count == 0, "R1", "miss_count after second reset", miss_count, 0);
        step("R1", 1'b0, 32'h0000_0100, '0, 1'b0);
        step("R1", 1'b0, 32'h0020_0008, '0, 1'b0);

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule